// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte-Lane Writes

This block is a clocked static memory with a 64-bit word and a depth set by a parameter. All synchronous inputs are captured on the rising clock edge. Output enable, sleep and burst-order select act at once, without a clock. The shared data bus is split into a write-data input and a read-data output. The read data is forced to zero whenever the bus would be released.

An access is opened by one of two active-low address strobes. The host-side strobe always opens a read, and that read may become a write on the next edge. The controller-side strobe opens a read or a write on its own edge, depending on the write controls it sees then. Once an access is open, the advance input walks the two low address bits through a group of four. The walk is either a linear order or an exclusive-or (interleaved) order. Holding advance inactive inserts wait states. Writes can cover any subset of the eight byte lanes, or all of them through a global write. A sleep input freezes the memory, and both strobes are refused for two edges after sleep is released.

Top module: `sbs_sram`

## Requirements
- R1: While reset is low, and after reset before any access, the read-data output is zero.
- R2: With global write high and byte-write enable low, lane-enable bit n (active low) writes data bits 8n+7 down to 8n and leaves every other byte of that word unchanged.
- R3: Global write low writes all 64 bits, whatever the byte-write enable and lane enables are.
- R4: An edge with global write high is a read if byte-write enable is high or if all eight lane enables are high. Memory is unchanged on that edge.
- R5: The host strobe (primary enable low) always reads on its own edge, even with write controls low. Write controls on the following edge, with no strobe and advance high, write that same address.
- R6: The host strobe is ignored while the primary enable is high. No access starts, and an open burst continues as if no strobe were present.
- R7: An edge with the controller strobe low opens an access only when the primary enable is low, the secondary enable high and the tertiary enable low. Otherwise it deselects, and the read data becomes zero. The secondary and tertiary enables have no effect on edges without a strobe.
- R8: On an edge that continues an open access with advance high, the address does not change (wait state).
- R9: On a continuing edge with advance low, the burst step k moves to k+1. The low two address bits become base+k mod 4 when order select is 1 (linear), and base XOR k when it is 0 (interleaved). The upper bits stay unchanged.
- R10: While sleep is high, no read or write takes place, stored contents are kept, the read data is zero and any open access is closed.
- R11: After sleep falls, both strobes are ignored on the first two rising edges. The third edge accepts them.
- R12: Read data is valid from the edge that performs the read until the next edge. It is zero while output enable is high, and after an edge that wrote, deselected or did nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | AW | Word address captured by a strobe |
| strobe_cpu_n | input | 1 | Host address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Tertiary chip enable, active low |
| glb_wr_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low, bit n is byte n |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down, active high, asynchronous |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when the bus is released |

## Verification
The assertions assume that sleep and output enable settle between clock edges, because they act without a clock. They also assume that reset is held for at least one edge before the first access. The stimulus meets both conditions: every input is changed on the falling edge, and reset stays low for several cycles. The array holds unknown values until it is written, so every word is written once through the controller strobe before any read compares data. After that, random single writes and four-beat bursts with random order and random waits draw their addresses from the whole array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   localparam int BURST_W = 2;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2,
      CYC_DESEL = 2'd3
   } cyc_e;

   function automatic logic [BURST_W-1:0] burst_low(
      input logic [BURST_W-1:0] base,
      input logic [BURST_W-1:0] step,
      input logic               lin);
      return lin ? BURST_W'(base + step) : (base ^ step);
   endfunction
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode #(
   parameter int LANES    = 8,
   parameter int WAKE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_cpu_n,
   input  logic             strobe_ctl_n,
   input  logic             adv_n,
   input  logic             ce_main_n,
   input  logic             ce_hi,
   input  logic             ce_lo_n,
   input  logic             glb_wr_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             sleep,
   output logic             load,
   output logic             step,
   output logic             acc,
   output logic [LANES-1:0] wmask,
   output sbs_pkg::cyc_e    cyc
);
   import sbs_pkg::*;

   localparam int WK_W = $clog2(WAKE_CYC + 1);

   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("sbs_decode: WAKE_CYC must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("sbs_decode: LANES must be at least 1");
   end

   logic [WK_W-1:0] wake_q;
   logic            active_q;
   logic            lock;
   logic            cpu_go;
   logic            ctl_go;
   logic            start;
   logic            sel_ok;
   logic            cont;

   // strobe qualification
   always_comb begin
      lock   = sleep || (wake_q != '0);
      cpu_go = !lock && !strobe_cpu_n && !ce_main_n;
      ctl_go = !lock && !cpu_go && !strobe_ctl_n;
      start  = cpu_go || ctl_go;
      sel_ok = start && !ce_main_n && ce_hi && !ce_lo_n;
      cont   = !lock && !start && active_q;
      load   = sel_ok;
      step   = cont && !adv_n;
      acc    = sel_ok || cont;
   end

   // write lane selection; host strobe edge is always a read
   always_comb begin
      wmask = '0;
      if (acc && !cpu_go) begin
         if (!glb_wr_n) begin
            wmask = '1;
         end else if (!bwe_n) begin
            wmask = ~lane_n;
         end
      end
   end

   always_comb begin
      if (!acc) begin
         cyc = (start && !sel_ok) ? CYC_DESEL : CYC_IDLE;
      end else if (|wmask) begin
         cyc = CYC_WRITE;
      end else begin
         cyc = CYC_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= '0;
      end else if (sleep) begin
         wake_q <= WK_W'(WAKE_CYC);
      end else if (wake_q != '0) begin
         wake_q <= wake_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (sleep) begin
         active_q <= 1'b0;
      end else if (load) begin
         active_q <= 1'b1;
      end else if (start) begin
         active_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          order_lin,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] eff_addr
);
   import sbs_pkg::*;

   localparam int HI_W = AW - BURST_W;

   if (AW <= BURST_W) begin : g_bad_aw
      $error("sbs_burst_ctr: AW must exceed the burst field width");
   end

   logic [AW-1:0]      base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_nx;
   logic [AW-1:0]      src;

   always_comb begin
      if (load) begin
         cnt_nx = '0;
      end else if (step) begin
         cnt_nx = cnt_q + 1'b1;
      end else begin
         cnt_nx = cnt_q;
      end
      src      = load ? addr_in : base_q;
      eff_addr = {src[AW-1 -: HI_W], burst_low(src[BURST_W-1:0], cnt_nx, order_lin)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (load) begin
            base_q <= addr_in;
         end
         cnt_q <= cnt_nx;
      end
   end
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
   parameter int AW     = 8,
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_en,
   output logic [LANES*LANE_W-1:0] rd_q
);
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wmask[g]) begin
            mem[addr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q[g*LANE_W +: LANE_W] <= '0;
         end else if (rd_en) begin
            rd_q[g*LANE_W +: LANE_W] <= mem[addr];
         end
      end
   end
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
   parameter int AW       = 8,
   parameter int LANES    = 8,
   parameter int LANE_W   = 8,
   parameter int WAKE_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   input  logic                    strobe_cpu_n,
   input  logic                    strobe_ctl_n,
   input  logic                    adv_n,
   input  logic                    ce_main_n,
   input  logic                    ce_hi,
   input  logic                    ce_lo_n,
   input  logic                    glb_wr_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        lane_n,
   input  logic                    order_lin,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   import sbs_pkg::*;

   localparam int DW = LANES * LANE_W;

   if (AW > 12) begin : g_bad_depth
      $error("sbs_sram: AW too large for a behavioural array");
   end

   logic          load;
   logic          step;
   logic          acc;
   logic [LANES-1:0] wmask;
   cyc_e          cyc;
   logic [AW-1:0] eff_addr;
   logic [DW-1:0] rd_q;
   logic          rvalid_q;

   sbs_decode #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
      .adv_n(adv_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .glb_wr_n(glb_wr_n), .bwe_n(bwe_n), .lane_n(lane_n), .sleep(sleep),
      .load(load), .step(step), .acc(acc), .wmask(wmask), .cyc(cyc)
   );

   sbs_burst_ctr #(.AW(AW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .order_lin(order_lin), .addr_in(addr), .eff_addr(eff_addr)
   );

   sbs_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .addr(eff_addr), .wmask(wmask),
      .wdata(wdata), .rd_en(cyc == CYC_READ), .rd_q(rd_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= (cyc == CYC_READ);
      end
   end

   assign rdata = (rvalid_q && !oe_n && !sleep) ? rd_q : '0;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
   parameter int AW    = 8,
   parameter int LANES = 8,
   parameter int DW    = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input logic             oe_n,
   input logic             strobe_cpu_n,
   input logic             ce_main_n,
   input logic             adv_n,
   input logic [DW-1:0]    rdata,
   input logic             acc,
   input logic             load,
   input logic             step,
   input logic [LANES-1:0] wmask,
   input logic [AW-1:0]    eff_addr
);
   logic [1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (since_q != 2'd3) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R1: output quiet under reset
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (rdata == '0);
      end
   end

   a_r12_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> rdata == '0);

   a_r10_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (!acc && wmask == '0 && rdata == '0));

   a_r5_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_cpu_n && !ce_main_n && !sleep) |-> wmask == '0);

   a_r11_wake_lock1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q >= 2'd1 && $past(sleep) && !sleep) |-> !load);

   a_r11_wake_lock2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q >= 2'd2 && $past(sleep, 2) && !$past(sleep) && !sleep) |-> !load);

   a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q >= 2'd1 && $past(acc) && acc && !load && adv_n) |-> $stable(eff_addr));

   a_r9_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q >= 2'd1 && step) |->
         (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2]) && eff_addr != $past(eff_addr)));
endmodule

bind sbs_sram sbs_sram_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
   .strobe_cpu_n(strobe_cpu_n), .ce_main_n(ce_main_n), .adv_n(adv_n),
   .rdata(rdata), .acc(acc), .load(load), .step(step),
   .wmask(wmask), .eff_addr(eff_addr)
);

// File: tb/tb_sbs_sram.sv
`timescale 1ns/1ps
module tb_sbs_sram;
   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
   logic ce_main_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
   logic glb_wr_n = 1'b1, bwe_n = 1'b1;
   logic [7:0] lane_n = 8'hFF;
   logic order_lin = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;

   logic [63:0] ref_mem [DEPTH];
   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sbs_sram #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .glb_wr_n(glb_wr_n), .bwe_n(bwe_n), .lane_n(lane_n),
      .order_lin(order_lin), .oe_n(oe_n), .sleep(sleep),
      .wdata(wdata), .rdata(rdata)
   );

   function automatic logic [63:0] bmask(input logic g_n, input logic b_n, input logic [7:0] ln);
      logic [63:0] m;
      m = '0;
      if (!g_n) m = '1;
      else if (!b_n) for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{~ln[i]}};
      return m;
   endfunction

   function automatic logic [AW-1:0] bexp(input logic [AW-1:0] b, input int k, input logic lin);
      logic [1:0] lo;
      lo = lin ? 2'(b[1:0] + 2'(k)) : (b[1:0] ^ 2'(k));
      return {b[AW-1:2], lo};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
      ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
      glb_wr_n = 1'b1; bwe_n = 1'b1; lane_n = 8'hFF; oe_n = 1'b0; sleep = 1'b0;
   endtask

   task automatic ctl_access(input logic [AW-1:0] a, input logic [63:0] d,
                             input logic g_n, input logic b_n, input logic [7:0] ln);
      logic [63:0] m;
      idle();
      strobe_ctl_n = 1'b0; addr = a; wdata = d; glb_wr_n = g_n; bwe_n = b_n; lane_n = ln;
      m = bmask(g_n, b_n, ln);
      @(negedge clk);
      ref_mem[a] = (ref_mem[a] & ~m) | (d & m);
      idle();
   endtask

   task automatic cpu_start(input logic [AW-1:0] a);
      idle();
      strobe_cpu_n = 1'b0; addr = a;
      @(negedge clk);
      idle();
   endtask

   task automatic read_check(input string req, input logic [AW-1:0] a);
      cpu_start(a);
      chk(req, rdata, ref_mem[a]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] a, b;
      logic [63:0] d;
      idle();
      repeat (3) @(negedge clk);
      chk("R1 in reset", rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", rdata, '0);

      for (int i = 0; i < DEPTH; i++) begin
         ctl_access(AW'(i), {$urandom(7 + i), $urandom}, 1'b0, 1'b1, 8'hFF);
      end
      chk("R12 after write", rdata, '0);

      // R2: single lanes
      a = 8'h21;
      ctl_access(a, 64'h1122334455667788, 1'b1, 1'b0, 8'hFE);
      read_check("R2 lane0", a);
      ctl_access(a, 64'hA5A5A5A5A5A5A5A5, 1'b1, 1'b0, 8'h5A);
      read_check("R2 mixed lanes", a);
      // R3: global overrides lanes
      ctl_access(a, 64'hDEADBEEFCAFEF00D, 1'b0, 1'b1, 8'hFF);
      read_check("R3 global", a);
      // R4: bwe low, no lanes -> read
      d = ref_mem[a];
      ctl_access(a, 64'h0, 1'b1, 1'b0, 8'hFF);
      chk("R4 read result", rdata, d);
      read_check("R4 unchanged", a);

      // R5: host strobe reads, next edge writes
      a = 8'h40;
      idle(); strobe_cpu_n = 1'b0; addr = a; glb_wr_n = 1'b0; wdata = 64'h0F0F0F0F12345678;
      @(negedge clk);
      chk("R5 strobe edge reads", rdata, ref_mem[a]);
      strobe_cpu_n = 1'b1; adv_n = 1'b1;
      @(negedge clk);
      ref_mem[a] = 64'h0F0F0F0F12345678;
      chk("R12 zero after write", rdata, '0);
      idle();
      read_check("R5 late write", a);

      // R7: deselect through secondary enable
      idle(); strobe_ctl_n = 1'b0; addr = 8'h10; ce_hi = 1'b0;
      @(negedge clk);
      chk("R7 deselect", rdata, '0);
      idle(); @(negedge clk);
      chk("R7 stays closed", rdata, '0);
      // R6: host strobe with primary high ignored
      idle(); strobe_cpu_n = 1'b0; addr = 8'h10; ce_main_n = 1'b1;
      @(negedge clk);
      chk("R6 ignored start", rdata, '0);
      cpu_start(8'h50);
      idle(); strobe_cpu_n = 1'b0; addr = 8'h90; ce_main_n = 1'b1;
      @(negedge clk);
      chk("R6 burst continues", rdata, ref_mem[8'h50]);
      // R7: enables ignored mid-burst
      idle(); ce_hi = 1'b0; ce_lo_n = 1'b1; adv_n = 1'b0;
      @(negedge clk);
      chk("R7 mid-burst enables", rdata, ref_mem[bexp(8'h50, 1, 1'b1)]);
      // R7: controller strobe with primary high deselects
      idle(); strobe_ctl_n = 1'b0; ce_main_n = 1'b1;
      @(negedge clk);
      chk("R7 primary high", rdata, '0);

      // R12: output enable gating
      cpu_start(8'h33);
      oe_n = 1'b1; #1;
      chk("R12 oe high", rdata, '0);
      oe_n = 1'b0; #1;
      chk("R12 oe low", rdata, ref_mem[8'h33]);

      // R10 / R11: sleep and wake lockout
      a = 8'h77;
      d = ref_mem[a];
      idle(); sleep = 1'b1; strobe_ctl_n = 1'b0; addr = a; glb_wr_n = 1'b0; wdata = 64'h1;
      @(negedge clk);
      chk("R10 output zero", rdata, '0);
      idle(); strobe_ctl_n = 1'b0; addr = a; glb_wr_n = 1'b0; wdata = 64'h2;
      @(negedge clk);
      chk("R11 edge1 ignored", rdata, '0);
      idle(); strobe_cpu_n = 1'b0; addr = a;
      @(negedge clk);
      chk("R11 edge2 ignored", rdata, '0);
      read_check("R10 contents kept", a);
      chk("R11 written nothing", ref_mem[a], d);

      // R8/R9 directed: wait then step, both orders
      for (int o = 0; o < 2; o++) begin
         order_lin = o[0];
         cpu_start(8'h86);
         order_lin = o[0];
         adv_n = 1'b1; @(negedge clk);
         chk("R8 wait holds", rdata, ref_mem[8'h86]);
         for (int k = 1; k < 4; k++) begin
            adv_n = 1'b0; @(negedge clk);
            chk("R9 step", rdata, ref_mem[bexp(8'h86, k, o[0])]);
         end
         idle();
      end

      // random mix
      for (int it = 0; it < 400; it++) begin
         a = AW'($urandom);
         if ($urandom_range(1, 0) == 0) begin
            ctl_access(a, {$urandom, $urandom}, ($urandom_range(3, 0) != 0),
                       1'($urandom), 8'($urandom));
         end else begin
            b = a;
            order_lin = 1'($urandom);
            cpu_start(b);
            chk("R12 burst beat0", rdata, ref_mem[b]);
            for (int k = 1; k < 4; k++) begin
               if ($urandom_range(2, 0) == 0) begin
                  adv_n = 1'b1; @(negedge clk);
                  chk("R8 random wait", rdata, ref_mem[bexp(b, k - 1, order_lin)]);
               end
               adv_n = 1'b0; @(negedge clk);
               chk("R9 random step", rdata, ref_mem[bexp(b, k, order_lin)]);
            end
            idle();
         end
      end
      for (int i = 0; i < 16; i++) read_check("R2 final sweep", AW'(i * 16 + 1));

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule